// File: doc/BRIEF.md
# Balanced I2S Stream Splitter

This block turns one stereo I2S stream into two I2S streams, one for each of two identical DACs that run in balanced (differential) mode. The first output stream carries the left sample in its first slot and the bitwise complement of that same left sample in its second slot. The second output stream does the same for the right sample. Each DAC therefore receives a signal and its polarity-inverted copy, and the two analogue outputs of a DAC form a balanced pair.

The input uses 32-bit slots and 64 bit clocks per frame. The block runs on the incoming bit clock. A 64-bit serial delay line gives three data taps: live, one slot late and one frame late. For each output, a per-slot multiplexer picks one tap and complements it when needed. The multiplexer select comes from a copy of word select that is delayed by one bit, so it lines up with the data slots. Both output word selects are the inverse of the input word select. They pass through the same single register stage as the data, so each output keeps the one-bit word-select lead that I2S requires.

Top module: `i2s_balanced_splitter`

## Requirements
- R1: While `arst_n` is low, all four outputs are 0. They go to 0 as soon as `arst_n` falls, without waiting for a clock edge.
- R2: After `arst_n` rises, all four outputs stay at 0 for at least the first 64 rising edges of `bclk`. Live data starts only once the full frame of delay holds input sampled after reset.
- R3: Once live, `out_l_ws` and `out_r_ws` are equal at all times. Sampled after rising edge t, each equals the inverse of `src_ws` as sampled at edge t.
- R4: Input framing follows I2S. `src_ws`=0 marks the left slot and `src_ws`=1 marks the right slot. The MSB comes on the first bit clock after a `src_ws` change, data is MSB first, and each slot is 32 bits. The first output slot of the left stream (`out_l_ws`=0) carries the left word unchanged.
- R5: The second output slot of the left stream (`out_l_ws`=1) carries the bitwise complement of that same left word.
- R6: The first output slot of the right stream (`out_r_ws`=0) carries the right word unchanged.
- R7: The second output slot of the right stream (`out_r_ws`=1) carries the bitwise complement of that same right word.
- R8: The left pair and the right pair from one input frame occupy the same output frame on both streams.
- R9: Every bit of a word stays in its own slot. This includes the MSB just after a word-select change and the LSB on the edge where word select changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Incoming I2S bit clock; all registers use its rising edge |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_ws | input | 1 | Input word select (0 = left slot) |
| src_sd | input | 1 | Input serial data, MSB first |
| out_l_ws | output | 1 | Word select of the left-pair stream |
| out_l_sd | output | 1 | Serial data: left word, then its complement |
| out_r_ws | output | 1 | Word select of the right-pair stream |
| out_r_sd | output | 1 | Serial data: right word, then its complement |

## Verification
The frames sent include a mixed word, all-ones against a lone LSB, a lone MSB against zero, alternating nibble patterns and an arbitrary pair. Each output stream is decoded as an I2S receiver would decode it and compared word by word.

The lone-MSB and lone-LSB words expose a select that switches one bit early or late, or a tap that is off by one position. A word of all ones or all zeros in one channel shows whether the complement is applied in the correct slot and only there. Distinct left and right words per frame expose crossed taps and a frame offset between the two streams.

A reset in the middle of a stream, followed by a fresh run, shows that the output stays quiet while the delay line refills.

// File: rtl/i2s_split_pkg.sv
`timescale 1ns/1ps
package i2s_split_pkg;

  // Default slot length in bit clocks; a frame is two slots.
  localparam int unsigned SLOT_BITS_DEF = 32;

  // Number of taps on the delay line and number of output streams.
  localparam int unsigned NUM_TAPS  = 3;
  localparam int unsigned NUM_LANES = 2;

  // Tap positions: live input, one slot late, one frame late.
  typedef enum logic [1:0] {
    TAP_LIVE  = 2'd0,
    TAP_SLOT  = 2'd1,
    TAP_FRAME = 2'd2
  } tap_sel_e;

  // Lane 0 builds the left pair, lane 1 builds the right pair.
  // The near tap feeds the plain slot and the far tap feeds the complement slot.
  function automatic tap_sel_e lane_near_tap(input int unsigned lane);
    return (lane == 0) ? TAP_SLOT : TAP_LIVE;
  endfunction

  function automatic tap_sel_e lane_far_tap(input int unsigned lane);
    return (lane == 0) ? TAP_FRAME : TAP_SLOT;
  endfunction

endpackage

// File: rtl/i2s_rst_sync.sv
`timescale 1ns/1ps
module i2s_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift ones in after release; assertion is immediate.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/i2s_tap_line.sv
`timescale 1ns/1ps
module i2s_tap_line
  import i2s_split_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_in,
  output logic [NUM_TAPS-1:0] taps
);

  localparam int unsigned DEPTH = 2 * SLOT_BITS;

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;

  always_comb begin
    line_d = {line_q[DEPTH-2:0], sd_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  // line_q[k] holds the bit that arrived k+1 edges ago.
  assign taps[int'(TAP_LIVE)]  = sd_in;
  assign taps[int'(TAP_SLOT)]  = line_q[SLOT_BITS-1];
  assign taps[int'(TAP_FRAME)] = line_q[DEPTH-1];

endmodule

// File: rtl/i2s_fill_track.sv
`timescale 1ns/1ps
module i2s_fill_track #(
  parameter int unsigned FILL_EDGES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic filled
);

  localparam int unsigned CW = $clog2(FILL_EDGES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(FILL_EDGES));

  // Counts edges since reset and stops at the delay-line depth.
  always_comb begin
    cnt_d = cnt_q;
    if (!at_limit) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign filled = at_limit;

endmodule

// File: rtl/i2s_balance_lane.sv
`timescale 1ns/1ps
module i2s_balance_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic slot_hi,
  input  logic ws_src,
  input  logic near_bit,
  input  logic far_bit,
  output logic ws_out,
  output logic sd_out
);

  logic ws_q;
  logic ws_d;
  logic sd_q;
  logic sd_d;

  // slot_hi is word select aligned to the data slot.
  // High: the plain copy from the near tap. Low: the complement from the far tap.
  always_comb begin
    ws_d = 1'b0;
    sd_d = 1'b0;
    if (load_en) begin
      ws_d = ~ws_src;
      sd_d = slot_hi ? near_bit : ~far_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b0;
      sd_q <= 1'b0;
    end else begin
      ws_q <= ws_d;
      sd_q <= sd_d;
    end
  end

  assign ws_out = ws_q;
  assign sd_out = sd_q;

endmodule

// File: rtl/i2s_balanced_splitter.sv
`timescale 1ns/1ps
module i2s_balanced_splitter
  import i2s_split_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = SLOT_BITS_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic bclk,
  input  logic arst_n,
  input  logic src_ws,
  input  logic src_sd,
  output logic out_l_ws,
  output logic out_l_sd,
  output logic out_r_ws,
  output logic out_r_sd
);

  localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;

  logic                 core_rst_n;
  logic [NUM_TAPS-1:0]  taps;
  logic                 fill_done;
  logic                 ws_al_q;
  logic                 ws_al_d;
  logic [NUM_LANES-1:0] lane_ws;
  logic [NUM_LANES-1:0] lane_sd;

  i2s_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (bclk),
    .arst_n    (arst_n),
    .rst_n_sync(core_rst_n)
  );

  i2s_tap_line #(
    .SLOT_BITS(SLOT_BITS)
  ) u_tap_line (
    .clk  (bclk),
    .rst_n(core_rst_n),
    .sd_in(src_sd),
    .taps (taps)
  );

  i2s_fill_track #(
    .FILL_EDGES(FRAME_BITS)
  ) u_fill (
    .clk   (bclk),
    .rst_n (core_rst_n),
    .filled(fill_done)
  );

  // Word select delayed one bit so that it lines up with the data slots.
  always_comb begin
    ws_al_d = src_ws;
  end

  always_ff @(posedge bclk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ws_al_q <= 1'b0;
    end else begin
      ws_al_q <= ws_al_d;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned NEAR_IDX = int'(lane_near_tap(g));
    localparam int unsigned FAR_IDX  = int'(lane_far_tap(g));

    i2s_balance_lane u_lane (
      .clk     (bclk),
      .rst_n   (core_rst_n),
      .load_en (fill_done),
      .slot_hi (ws_al_q),
      .ws_src  (src_ws),
      .near_bit(taps[NEAR_IDX]),
      .far_bit (taps[FAR_IDX]),
      .ws_out  (lane_ws[g]),
      .sd_out  (lane_sd[g])
    );
  end

  assign out_l_ws = lane_ws[0];
  assign out_l_sd = lane_sd[0];
  assign out_r_ws = lane_ws[1];
  assign out_r_sd = lane_sd[1];

endmodule

// File: rtl/i2s_balanced_splitter_chk.sv
`timescale 1ns/1ps
module i2s_balanced_splitter_chk #(
  parameter int unsigned SLOT_BITS = 32
) (
  input logic clk,
  input logic arst_n,
  input logic src_ws,
  input logic out_l_ws,
  input logic out_l_sd,
  input logic out_r_ws,
  input logic out_r_sd
);

  localparam int unsigned QUIET = 2 * SLOT_BITS;
  localparam int unsigned WARM  = 4 * SLOT_BITS + 8;
  localparam int unsigned CW    = $clog2(WARM + 1);

  logic [CW-1:0]        edge_cnt;
  logic [SLOT_BITS-1:0] hist_l;
  logic [SLOT_BITS-1:0] hist_r;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      edge_cnt <= '0;
      hist_l   <= '0;
      hist_r   <= '0;
    end else begin
      if (edge_cnt != CW'(WARM)) begin
        edge_cnt <= edge_cnt + CW'(1);
      end
      hist_l <= {hist_l[SLOT_BITS-2:0], out_l_sd};
      hist_r <= {hist_r[SLOT_BITS-2:0], out_r_sd};
    end
  end

  assert_rst_clear_R1: assert property (@(posedge clk)
    !arst_n |-> (!out_l_ws && !out_l_sd && !out_r_ws && !out_r_sd));

  assert_fill_quiet_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (edge_cnt < CW'(QUIET)) |-> (!out_l_ws && !out_l_sd && !out_r_ws && !out_r_sd));

  assert_ws_inverse_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (edge_cnt == CW'(WARM)) |-> (out_l_ws == !$past(src_ws)));

  assert_ws_pair_R3: assert property (@(posedge clk) disable iff (!arst_n)
    out_l_ws == out_r_ws);

  // A complement-slot bit is the inverse of the bit one slot earlier.
  assert_compl_l_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (edge_cnt == CW'(WARM) && $past(out_l_ws)) |-> (out_l_sd == !hist_l[SLOT_BITS-1]));

  assert_compl_r_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (edge_cnt == CW'(WARM) && $past(out_r_ws)) |-> (out_r_sd == !hist_r[SLOT_BITS-1]));

endmodule

bind i2s_balanced_splitter i2s_balanced_splitter_chk #(
  .SLOT_BITS(SLOT_BITS)
) u_chk (
  .clk     (bclk),
  .arst_n  (arst_n),
  .src_ws  (src_ws),
  .out_l_ws(out_l_ws),
  .out_l_sd(out_l_sd),
  .out_r_ws(out_r_ws),
  .out_r_sd(out_r_sd)
);

// File: tb/tb_i2s_balanced_splitter.sv
`timescale 1ns/1ps
module tb_i2s_balanced_splitter;

  logic bclk;
  logic arst_n;
  logic src_ws;
  logic src_sd;
  logic out_l_ws;
  logic out_l_sd;
  logic out_r_ws;
  logic out_r_sd;

  i2s_balanced_splitter dut (
    .bclk    (bclk),
    .arst_n  (arst_n),
    .src_ws  (src_ws),
    .src_sd  (src_sd),
    .out_l_ws(out_l_ws),
    .out_l_sd(out_l_sd),
    .out_r_ws(out_r_ws),
    .out_r_sd(out_r_sd)
  );

  initial bclk = 1'b0;
  always #2.5 bclk = ~bclk;

  // Each row is {left, ~left, right, ~right}.
  localparam int NVEC = 6;
  localparam logic [127:0] VEC [NVEC] = '{
    {32'h1234_5678, 32'hEDCB_A987, 32'h9ABC_DEF0, 32'h6543_210F},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFE},
    {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'hA5A5_A5A5},
    {32'h0000_0001, 32'hFFFF_FFFE, 32'h8000_0000, 32'h7FFF_FFFF},
    {32'h0F0F_00FF, 32'hF0F0_FF00, 32'hDEAD_BEEF, 32'h2152_4110}
  };

  int checks;
  int fails;
  int since_rel;
  bit done;
  logic last_lsb;

  // Receiver state for each output stream.
  logic [31:0] sh_l, sh_r, hold_l, hold_r;
  logic        wsp_l, wsp_r;
  logic [31:0] pl0 [32];
  logic [31:0] pl1 [32];
  logic [31:0] pr0 [32];
  logic [31:0] pr1 [32];
  int          np_l, np_r;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_rx();
    sh_l = '0; sh_r = '0; hold_l = '0; hold_r = '0;
    wsp_l = 1'b0; wsp_r = 1'b0; np_l = 0; np_r = 0;
  endtask

  task automatic sample();
    logic [31:0] w;
    if (arst_n) since_rel++;
    if (arst_n && since_rel <= 64)
      check(!out_l_ws && !out_l_sd && !out_r_ws && !out_r_sd, "R2 quiet fill",
            {28'd0, out_l_ws, out_l_sd, out_r_ws, out_r_sd}, 32'd0);
    if (arst_n && since_rel >= 72)
      check(out_l_ws === ~src_ws && out_r_ws === out_l_ws, "R3 ws inverse",
            {30'd0, out_l_ws, out_r_ws}, {30'd0, ~src_ws, ~src_ws});
    w = {sh_l[30:0], out_l_sd};
    if (out_l_ws !== wsp_l) begin
      if (wsp_l == 1'b0) hold_l = w;
      else if (np_l < 32) begin pl0[np_l] = hold_l; pl1[np_l] = w; np_l++; end
    end
    sh_l = w; wsp_l = out_l_ws;
    w = {sh_r[30:0], out_r_sd};
    if (out_r_ws !== wsp_r) begin
      if (wsp_r == 1'b0) hold_r = w;
      else if (np_r < 32) begin pr0[np_r] = hold_r; pr1[np_r] = w; np_r++; end
    end
    sh_r = w; wsp_r = out_r_ws;
  endtask

  task automatic tick(input logic ws, input logic sd);
    @(negedge bclk);
    sample();
    src_ws = ws;
    src_sd = sd;
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
    tick(1'b0, last_lsb);
    for (int i = 31; i >= 1; i--) tick(1'b0, l[i]);
    tick(1'b1, l[0]);
    for (int i = 31; i >= 1; i--) tick(1'b1, r[i]);
    last_lsb = r[0];
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    src_ws = 1'b0;
    src_sd = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge bclk);
      check(!out_l_ws && !out_l_sd && !out_r_ws && !out_r_sd, "R1 reset state",
            {28'd0, out_l_ws, out_l_sd, out_r_ws, out_r_sd}, 32'd0);
    end
    since_rel = 0;
    last_lsb = 1'b0;
    arst_n = 1'b1;
  endtask

  task automatic run_table();
    int base;
    bit found;
    clear_rx();
    send_frame(32'd0, 32'd0);
    send_frame(32'd0, 32'd0);
    for (int k = 0; k < NVEC; k++) send_frame(VEC[k][127:96], VEC[k][63:32]);
    send_frame(32'd0, 32'd0);
    send_frame(32'd0, 32'd0);
    found = 1'b0;
    base = 0;
    for (int j = 0; j < np_l; j++) begin
      if (!found && pl0[j] == VEC[0][127:96]) begin found = 1'b1; base = j; end
    end
    check(found, "R4 first left word located", pl0[0], VEC[0][127:96]);
    check(found && base < np_r && pr0[base] == VEC[0][63:32], "R8 same output frame",
          pr0[base], VEC[0][63:32]);
    for (int k = 0; k < NVEC; k++) begin
      int idx;
      idx = base + k;
      if (found && idx < np_l && idx < np_r) begin
        // Rows 2 and 4 hold lone MSB and lone LSB words (R9 slot edges).
        check(pl0[idx] == VEC[k][127:96], (k == 2 || k == 4) ? "R4 R9 left plain" : "R4 left plain",
              pl0[idx], VEC[k][127:96]);
        check(pl1[idx] == VEC[k][95:64], "R5 left complement", pl1[idx], VEC[k][95:64]);
        check(pr0[idx] == VEC[k][63:32], (k == 2 || k == 4) ? "R6 R9 right plain" : "R6 right plain",
              pr0[idx], VEC[k][63:32]);
        check(pr1[idx] == VEC[k][31:0], "R7 right complement", pr1[idx], VEC[k][31:0]);
      end else begin
        check(1'b0, "R4 R6 frame missing", idx, np_l);
      end
    end
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0; since_rel = 0; last_lsb = 1'b0;
    arst_n = 1'b1; src_ws = 1'b0; src_sd = 1'b0;
    clear_rx();
    #1;
    do_reset();
    run_table();
    // Partial frame, then an asynchronous reset in mid-cycle.
    for (int i = 0; i < 20; i++) tick(1'b0, i[0]);
    #1;
    arst_n = 1'b0;
    #0.5;
    check(!out_l_ws && !out_l_sd && !out_r_ws && !out_r_sd, "R1 async clear",
          {28'd0, out_l_ws, out_l_sd, out_r_ws, out_r_sd}, 32'd0);
    do_reset();
    run_table();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule